// File: doc/BRIEF.md
# UDP Transmit Segmenter and Header Builder

This block carries out a send command: it moves a programmed total byte count out of a byte-wide transmit FIFO and onto an 8-bit valid/ready/last stream toward an Ethernet MAC. The bytes leave as a series of Ethernet/IPv4/UDP frames. Every frame carries the programmed payload length, except the final one, which carries whatever is left of the total. Each header is assembled from network parameters that are captured when the command starts. The IPv4 header checksum is computed before the first header byte goes out.

Software programs a total length and a payload length through write strobes. It pulses `start` while the block is idle, then watches `busy` and the count of bytes not yet sent. The payload source is a first-word-fall-through FIFO read port. It exposes an empty flag and an occupancy count. A frame begins only when the FIFO already holds that frame's whole payload, so the output stream never stalls part way through a frame for lack of data.

Top module: `udp_tx_framer`

## Requirements
- R1: After reset, `busy`, `tx_valid` and `fifo_rd_en` are 0 and `remain` is 0.
- R2: A `start` pulse while `busy` is 0 and the stored total length is nonzero sets `busy` to 1 on the next cycle, with `remain` equal to that total. A `start` while busy, or with a stored total of 0, is ignored. The total used is the value stored before the cycle of `start`.
- R3: The payload length resets to PAY_DEFAULT. A `pay_wr` write takes effect only while idle and only for a value in 1..PAY_MAX; any other write is ignored. The payload length and the total length keep their values across commands.
- R4: Each frame carries min(payload length, bytes remaining) payload bytes, taken from the FIFO in order.
- R5: Frame bytes use these offsets from 0, most significant byte first:
  - 0-5: peer MAC
  - 6-11: local MAC
  - 12-13: 0x0800
  - 14: 0x45
  - 15: 0x00
  - 16-17: payload+28
  - 18-19: identification
  - 20-21: 0x0000
  - 22: 64
  - 23: 17
  - 24-25: checksum
  - 26-29: local IP
  - 30-33: peer IP
  - 34-35: local port
  - 36-37: peer port
  - 38-39: payload+8
  - 40-41: 0x0000
  - 42 onward: the payload
- R6: Bytes 24-25 hold the one's complement of the end-around-carry sum of the ten 16-bit words at offsets 14-33, with the checksum field counted as zero.
- R7: Identification is 0 after reset and rises by one per frame, continuing across commands.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid`, `tx_data` and `tx_last` hold their values into the next cycle.
- R9: `tx_last` is 1 on exactly the final byte of each frame, so a frame is 42 + payload bytes long.
- R10: The FIFO is first-word-fall-through: `fifo_rd_data` shows the head and `fifo_rd_en` pops it. No frame begins until `fifo_count` is at least that frame's payload length, and `fifo_rd_en` is never 1 while `fifo_empty` is 1.
- R11: `remain` falls by one for each payload byte accepted on the stream. `busy` falls in the cycle after the final byte of the final frame is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_own_mac | input | 48 | Local MAC address |
| cfg_dst_mac | input | 48 | Peer MAC address |
| cfg_own_ip | input | 32 | Local IPv4 address |
| cfg_dst_ip | input | 32 | Peer IPv4 address |
| cfg_own_port | input | 16 | Local UDP port |
| cfg_dst_port | input | 16 | Peer UDP port for the send direction |
| tot_wr | input | 1 | Write strobe for the total length |
| tot_wdata | input | LEN_W | Total length value |
| pay_wr | input | 1 | Write strobe for the payload length |
| pay_wdata | input | PAY_W | Payload length value |
| start | input | 1 | Start a send command |
| busy | output | 1 | Command in progress |
| remain | output | LEN_W | Payload bytes not yet sent |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_count | input | CNT_W | FIFO occupancy in bytes |
| fifo_rd_data | input | 8 | FIFO head byte |
| fifo_rd_en | output | 1 | Pop the FIFO head |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Sink accepts the byte |

## Verification
On every cycle, the assertions check the following:
- the output hold rule under backpressure;
- that `busy` rises after an accepted start;
- that the payload length stays frozen while busy;
- that the FIFO is never popped while empty;
- that `remain` falls by exactly one per pop;
- that `busy` drops right after the final byte.

Only the bench's scenarios can show the rest. That covers the split of a total into full frames and a remainder, the byte-exact header and checksum, identification continuing across commands, and the rejection of invalid, mid-command and zero-total settings. It also covers holding a frame back until the FIFO holds its full payload.

// File: rtl/udp_tx_pkg.sv
`timescale 1ns/1ps
package udp_tx_pkg;
   localparam int HDR_BYTES    = 42;
   localparam int IP_HDR_WORDS = 10;
   localparam int IP_OVERHEAD  = 28;
   localparam int UDP_OVERHEAD = 8;

   localparam logic [15:0] ETYPE_IPV4   = 16'h0800;
   localparam logic [7:0]  IP_VER_IHL   = 8'h45;
   localparam logic [7:0]  IP_TOS       = 8'h00;
   localparam logic [7:0]  IP_TTL       = 8'd64;
   localparam logic [7:0]  IP_PROTO_UDP = 8'd17;

   typedef struct packed {
      logic [47:0] own_mac;
      logic [47:0] dst_mac;
      logic [31:0] own_ip;
      logic [31:0] dst_ip;
      logic [15:0] own_port;
      logic [15:0] dst_port;
   } net_cfg_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_SUM,
      ST_HDR,
      ST_PAY
   } seg_state_t;
endpackage

// File: rtl/udp_ip_csum.sv
`timescale 1ns/1ps
module udp_ip_csum #(
   parameter int NWORDS = 10,
   parameter bit SERIAL = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    go,
   input  logic [NWORDS-1:0][15:0] words,
   output logic                    done,
   output logic [15:0]             csum
);
   localparam int IDX_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
   localparam int SUM_W = 16 + $clog2(NWORDS + 1);

   logic [15:0] acc_q;
   logic        done_q;

   assign csum = ~acc_q;
   assign done = done_q;

   if (NWORDS < 2) begin : g_bad_nwords
      $error("udp_ip_csum: NWORDS must be at least 2");
   end

   generate
      if (SERIAL) begin : g_serial
         // one word per cycle, end-around carry folded at every step
         logic [IDX_W-1:0] idx_q;
         logic             run_q;
         logic [16:0]      sum17;

         assign sum17 = {1'b0, acc_q} + {1'b0, words[idx_q]};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q  <= '0;
               idx_q  <= '0;
               run_q  <= 1'b0;
               done_q <= 1'b0;
            end else begin
               done_q <= 1'b0;
               if (go) begin
                  acc_q <= '0;
                  idx_q <= '0;
                  run_q <= 1'b1;
               end else if (run_q) begin
                  acc_q <= sum17[15:0] + {15'd0, sum17[16]};
                  if (idx_q == IDX_W'(NWORDS - 1)) begin
                     run_q  <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     idx_q <= idx_q + IDX_W'(1);
                  end
               end
            end
         end
      end else begin : g_parallel
         // adder tree in one cycle, folded twice
         logic [SUM_W-1:0] wide;
         logic [16:0]      fold1;
         logic [15:0]      fold2;

         always_comb begin
            wide = '0;
            for (int i = 0; i < NWORDS; i++) begin
               wide = wide + SUM_W'(words[i]);
            end
            fold1 = {1'b0, wide[15:0]} + 17'(wide[SUM_W-1:16]);
            fold2 = fold1[15:0] + {15'd0, fold1[16]};
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q  <= '0;
               done_q <= 1'b0;
            end else begin
               done_q <= go;
               if (go) acc_q <= fold2;
            end
         end
      end
   endgenerate

   // R6: a result is only announced one cycle at a time
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/udp_hdr_bytes.sv
`timescale 1ns/1ps
module udp_hdr_bytes
   import udp_tx_pkg::*;
(
   input  net_cfg_t    cfg,
   input  logic [15:0] ip_len,
   input  logic [15:0] udp_len,
   input  logic [15:0] ident,
   input  logic [15:0] csum,
   input  logic [5:0]  idx,
   output logic [7:0]  byte_o
);
   localparam int HDR_BITS = HDR_BYTES * 8;

   logic [HDR_BITS-1:0] hdr_vec;

   // first transmitted byte sits in the top bits
   assign hdr_vec = {cfg.dst_mac, cfg.own_mac, ETYPE_IPV4,
                     IP_VER_IHL, IP_TOS, ip_len, ident, 16'h0000,
                     IP_TTL, IP_PROTO_UDP, csum, cfg.own_ip, cfg.dst_ip,
                     cfg.own_port, cfg.dst_port, udp_len, 16'h0000};

   always_comb begin
      if (int'(idx) < HDR_BYTES) byte_o = hdr_vec[HDR_BITS - 1 - 8 * int'(idx) -: 8];
      else                       byte_o = 8'h00;
   end
endmodule

// File: rtl/udp_tx_framer.sv
`timescale 1ns/1ps
module udp_tx_framer
   import udp_tx_pkg::*;
#(
   parameter int LEN_W       = 32,
   parameter int PAY_W       = 16,
   parameter int PAY_MAX     = 16000,
   parameter int PAY_DEFAULT = 1472,
   parameter int CNT_W       = 16,
   parameter int IDENT_INIT  = 0,
   parameter bit CSUM_SERIAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [47:0]      cfg_own_mac,
   input  logic [47:0]      cfg_dst_mac,
   input  logic [31:0]      cfg_own_ip,
   input  logic [31:0]      cfg_dst_ip,
   input  logic [15:0]      cfg_own_port,
   input  logic [15:0]      cfg_dst_port,
   input  logic             tot_wr,
   input  logic [LEN_W-1:0] tot_wdata,
   input  logic             pay_wr,
   input  logic [PAY_W-1:0] pay_wdata,
   input  logic             start,
   output logic             busy,
   output logic [LEN_W-1:0] remain,
   input  logic             fifo_empty,
   input  logic [CNT_W-1:0] fifo_count,
   input  logic [7:0]       fifo_rd_data,
   output logic             fifo_rd_en,
   output logic             tx_valid,
   output logic [7:0]       tx_data,
   output logic             tx_last,
   input  logic             tx_ready
);
   localparam int HIDX_W   = 6;
   localparam int HDR_LAST = HDR_BYTES - 1;

   // elaboration checks on the parameter set
   if (PAY_MAX < 1 || PAY_MAX + IP_OVERHEAD > 65535) begin : g_bad_max
      $error("udp_tx_framer: PAY_MAX out of range");
   end
   if (PAY_DEFAULT < 1 || PAY_DEFAULT > PAY_MAX) begin : g_bad_default
      $error("udp_tx_framer: PAY_DEFAULT outside 1..PAY_MAX");
   end
   if (PAY_W > 16 || PAY_W > LEN_W || (2 ** PAY_W) <= PAY_MAX) begin : g_bad_payw
      $error("udp_tx_framer: PAY_W cannot hold PAY_MAX");
   end
   if (CNT_W < $clog2(PAY_MAX + 1)) begin : g_bad_cnt
      $error("udp_tx_framer: CNT_W too narrow for a full payload");
   end

   seg_state_t        st_q;
   logic [LEN_W-1:0]  tot_q, rem_q;
   logic [PAY_W-1:0]  pay_q, flen_q, pidx_q, next_len;
   logic [15:0]       ident_q;
   logic [HIDX_W-1:0] hidx_q;
   net_cfg_t          cfg_q, cfg_in;
   logic              sum_go_q, sum_done, fifo_enough, pay_ok, at_pay_end;
   logic [15:0]       sum_val, ip_len, udp_len, hdr_byte;
   logic [IP_HDR_WORDS-1:0][15:0] ip_words;

   assign cfg_in = {cfg_own_mac, cfg_dst_mac, cfg_own_ip, cfg_dst_ip,
                    cfg_own_port, cfg_dst_port};

   assign next_len    = (rem_q < LEN_W'(pay_q)) ? rem_q[PAY_W-1:0] : pay_q;
   assign fifo_enough = (32'(fifo_count) >= 32'(next_len));
   assign pay_ok      = (pay_wdata != '0) && (32'(pay_wdata) <= 32'(PAY_MAX));
   assign at_pay_end  = (pidx_q == flen_q - PAY_W'(1));

   assign ip_len  = 16'(flen_q) + 16'(IP_OVERHEAD);
   assign udp_len = 16'(flen_q) + 16'(UDP_OVERHEAD);

   // IPv4 header words, checksum field counted as zero
   assign ip_words[0] = {IP_VER_IHL, IP_TOS};
   assign ip_words[1] = ip_len;
   assign ip_words[2] = ident_q;
   assign ip_words[3] = 16'h0000;
   assign ip_words[4] = {IP_TTL, IP_PROTO_UDP};
   assign ip_words[5] = 16'h0000;
   assign ip_words[6] = cfg_q.own_ip[31:16];
   assign ip_words[7] = cfg_q.own_ip[15:0];
   assign ip_words[8] = cfg_q.dst_ip[31:16];
   assign ip_words[9] = cfg_q.dst_ip[15:0];

   udp_ip_csum #(
      .NWORDS (IP_HDR_WORDS),
      .SERIAL (CSUM_SERIAL)
   ) u_csum (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (sum_go_q),
      .words (ip_words),
      .done  (sum_done),
      .csum  (sum_val)
   );

   logic [7:0] hdr_b;
   udp_hdr_bytes u_hdr (
      .cfg     (cfg_q),
      .ip_len  (ip_len),
      .udp_len (udp_len),
      .ident   (ident_q),
      .csum    (sum_val),
      .idx     (hidx_q),
      .byte_o  (hdr_b)
   );
   assign hdr_byte = {8'h00, hdr_b};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         tot_q    <= '0;
         rem_q    <= '0;
         pay_q    <= PAY_W'(PAY_DEFAULT);
         flen_q   <= '0;
         pidx_q   <= '0;
         hidx_q   <= '0;
         ident_q  <= 16'(IDENT_INIT);
         cfg_q    <= '0;
         sum_go_q <= 1'b0;
      end else begin
         sum_go_q <= 1'b0;
         if (tot_wr) tot_q <= tot_wdata;
         if (pay_wr && st_q == ST_IDLE && pay_ok) pay_q <= pay_wdata;
         case (st_q)
            ST_IDLE: begin
               if (start && tot_q != '0) begin
                  rem_q <= tot_q;
                  cfg_q <= cfg_in;
                  st_q  <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (fifo_enough) begin
                  flen_q   <= next_len;
                  sum_go_q <= 1'b1;
                  st_q     <= ST_SUM;
               end
            end
            ST_SUM: begin
               if (sum_done) begin
                  hidx_q <= '0;
                  st_q   <= ST_HDR;
               end
            end
            ST_HDR: begin
               if (tx_ready) begin
                  if (hidx_q == HIDX_W'(HDR_LAST)) begin
                     pidx_q <= '0;
                     st_q   <= ST_PAY;
                  end else begin
                     hidx_q <= hidx_q + HIDX_W'(1);
                  end
               end
            end
            ST_PAY: begin
               if (tx_ready) begin
                  rem_q <= rem_q - LEN_W'(1);
                  if (at_pay_end) begin
                     ident_q <= ident_q + 16'd1;
                     st_q    <= (rem_q == LEN_W'(1)) ? ST_IDLE : ST_WAIT;
                  end else begin
                     pidx_q <= pidx_q + PAY_W'(1);
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (st_q != ST_IDLE);
   assign remain     = rem_q;
   assign tx_valid   = (st_q == ST_HDR) || (st_q == ST_PAY);
   assign tx_data    = (st_q == ST_PAY) ? fifo_rd_data : hdr_byte[7:0];
   assign tx_last    = (st_q == ST_PAY) && at_pay_end;
   assign fifo_rd_en = (st_q == ST_PAY) && tx_ready;

   // R8: stream holds under backpressure
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last));

   // R2: accepted start raises busy with the stored total
   p_busy_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && start && tot_q != '0 |=> busy && remain == $past(tot_q));

   // R3: payload length frozen during a command
   p_pay_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(pay_q));

   // R10: never pop an empty FIFO
   p_no_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd_en |-> !fifo_empty);

   // R11: remaining count falls by one per pop
   p_remain_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd_en |=> remain == $past(remain) - LEN_W'(1));

   // R11: busy drops right after the final byte
   p_idle_after_final_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready && tx_last && remain == LEN_W'(1) |=> !busy);
endmodule

// File: tb/udp_tx_framer_bench.sv
`timescale 1ns/1ps
module udp_tx_framer_bench;
   localparam int PAY_MAX = 40;
   localparam int PAY_DEF = 7;
   localparam int CNT_W   = 8;
   localparam logic [47:0] OWN_MAC  = 48'h0211_2233_4455;
   localparam logic [47:0] DST_MAC  = 48'h0ABB_CCDD_EE01;
   localparam logic [31:0] OWN_IP   = 32'hC0A8_0101;
   localparam logic [31:0] DST_IP   = 32'hC0A8_0164;
   localparam logic [15:0] OWN_PORT = 16'd4000;
   localparam logic [15:0] DST_PORT = 16'hF00D;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n = 1'b0;
   logic tot_wr = 1'b0, pay_wr = 1'b0, start = 1'b0, tx_ready = 1'b0;
   logic [31:0] tot_wdata = '0;
   logic [15:0] pay_wdata = '0;
   logic busy, fifo_rd_en, tx_valid, tx_last, fifo_empty;
   logic [31:0] remain;
   logic [7:0] tx_data, fifo_rd_data;
   logic [CNT_W-1:0] fifo_count;

   // first-word-fall-through FIFO model
   logic [7:0] fmem [0:255];
   int wp = 0;
   int rp = 0;
   int gpush = 0;
   assign fifo_count   = CNT_W'(wp - rp);
   assign fifo_empty   = (wp == rp);
   assign fifo_rd_data = fmem[rp[7:0]];
   always @(posedge clk) if (fifo_rd_en) rp <= rp + 1;

   udp_tx_framer #(
      .PAY_MAX (PAY_MAX), .PAY_DEFAULT (PAY_DEF), .CNT_W (CNT_W)
   ) u_udp_tx_framer (
      .clk (clk), .rst_n (rst_n),
      .cfg_own_mac (OWN_MAC), .cfg_dst_mac (DST_MAC),
      .cfg_own_ip (OWN_IP), .cfg_dst_ip (DST_IP),
      .cfg_own_port (OWN_PORT), .cfg_dst_port (DST_PORT),
      .tot_wr (tot_wr), .tot_wdata (tot_wdata),
      .pay_wr (pay_wr), .pay_wdata (pay_wdata), .start (start),
      .busy (busy), .remain (remain),
      .fifo_empty (fifo_empty), .fifo_count (fifo_count),
      .fifo_rd_data (fifo_rd_data), .fifo_rd_en (fifo_rd_en),
      .tx_valid (tx_valid), .tx_data (tx_data), .tx_last (tx_last),
      .tx_ready (tx_ready)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] pat(input int n);
      return 8'(n * 37 + 11);
   endfunction

   function automatic logic [15:0] exp_csum(input int plen, input int id);
      int s;
      s = 32'h4500 + (plen + 28) + (id & 16'hFFFF) + 32'h4011
        + int'(OWN_IP[31:16]) + int'(OWN_IP[15:0])
        + int'(DST_IP[31:16]) + int'(DST_IP[15:0]);
      while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
      return ~s[15:0];
   endfunction

   function automatic logic [7:0] exp_hdr(input int i, input int plen, input int id);
      logic [15:0] ipl, ul, idw;
      ipl = 16'(plen + 28);
      ul  = 16'(plen + 8);
      idw = 16'(id);
      if (i < 6)  return 8'(DST_MAC >> (8 * (5 - i)));
      if (i < 12) return 8'(OWN_MAC >> (8 * (11 - i)));
      if (i == 12) return 8'h08;
      if (i == 14) return 8'h45;
      if (i == 16) return ipl[15:8];
      if (i == 17) return ipl[7:0];
      if (i == 18) return idw[15:8];
      if (i == 19) return idw[7:0];
      if (i == 22) return 8'd64;
      if (i == 23) return 8'd17;
      if (i >= 26 && i < 30) return 8'(OWN_IP >> (8 * (29 - i)));
      if (i >= 30 && i < 34) return 8'(DST_IP >> (8 * (33 - i)));
      if (i == 34) return OWN_PORT[15:8];
      if (i == 35) return OWN_PORT[7:0];
      if (i == 36) return DST_PORT[15:8];
      if (i == 37) return DST_PORT[7:0];
      if (i == 38) return ul[15:8];
      if (i == 39) return ul[7:0];
      return 8'h00;
   endfunction

   // expected model
   int  exp_rem = 0;
   int  exp_pkl = PAY_DEF;
   int  exp_ident = 0;
   int  gexp = 0;
   logic [7:0] fb [0:127];
   int  fcnt = 0;
   bit  rem_bad = 0, hold_pend = 0, fall_pend = 0, saw_valid = 0, all_rdy = 0;
   logic [7:0] hold_d;
   logic hold_l;
   logic [15:0] lfsr = 16'hACE1;

   task automatic end_frame();
      int plen;
      bit ok;
      plen = (exp_rem < exp_pkl) ? exp_rem : exp_pkl;
      chk(fcnt == 42 + plen, "R9", "frame length at last", fcnt, 42 + plen);
      ok = 1;
      for (int i = 0; i < 42; i++)
         if (i != 24 && i != 25 && fb[i] != exp_hdr(i, plen, exp_ident)) ok = 0;
      chk(ok, "R5", "header bytes", ok, 1);
      chk({fb[24], fb[25]} == exp_csum(plen, exp_ident), "R6", "ip checksum",
          {fb[24], fb[25]}, exp_csum(plen, exp_ident));
      chk({fb[18], fb[19]} == 16'(exp_ident), "R7", "identification",
          {fb[18], fb[19]}, exp_ident);
      ok = 1;
      for (int i = 0; i < plen && 42 + i < 128; i++)
         if (fb[42 + i] != pat(gexp + i)) ok = 0;
      chk(ok, "R4", "payload split/content", ok, 1);
      chk(!rem_bad, "R11", "remain tracking in frame", rem_bad, 0);
      gexp += plen;
      exp_rem -= plen;
      exp_ident++;
      fcnt = 0;
      rem_bad = 0;
      if (exp_rem <= 0) fall_pend = 1;
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (hold_pend)
            chk(tx_valid && tx_data == hold_d && tx_last == hold_l, "R8",
                "hold under backpressure", tx_data, hold_d);
         if (fall_pend) begin
            chk(!busy, "R11", "busy falls after final byte", busy, 0);
            fall_pend = 0;
         end
         if (busy && remain != 32'(exp_rem - ((fcnt > 42) ? fcnt - 42 : 0))) rem_bad = 1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         tx_ready = all_rdy ? 1'b1 : (lfsr[0] | lfsr[1]);
         hold_pend = tx_valid && !tx_ready;
         hold_d = tx_data;
         hold_l = tx_last;
         if (tx_valid) saw_valid = 1;
         if (tx_valid && tx_ready) begin
            if (fcnt < 128) fb[fcnt] = tx_data;
            fcnt++;
            if (tx_last) end_frame();
            else if (fcnt > 90) begin
               chk(0, "R9", "missing last", fcnt, 0);
               fcnt = 0;
            end
         end
      end
   end

   task automatic push_bytes(input int n);
      for (int k = 0; k < n; k++) begin
         fmem[wp % 256] = pat(gpush);
         gpush++;
         wp++;
      end
   endtask

   task automatic write_tot(input int v);
      @(negedge clk); tot_wr = 1; tot_wdata = 32'(v);
      @(negedge clk); tot_wr = 0;
   endtask

   task automatic write_pay(input int v);
      @(negedge clk); pay_wr = 1; pay_wdata = 16'(v);
      @(negedge clk); pay_wr = 0;
   endtask

   task automatic do_start(input int total);
      @(negedge clk); start = 1; exp_rem = total;
      @(negedge clk); start = 0;
      chk(busy == 1'b1, "R2", "busy after start", busy, 1);
      chk(remain == 32'(total), "R2", "remain loaded", remain, total);
   endtask

   task automatic wait_idle();
      int guard;
      guard = 0;
      while (busy && guard < 20000) begin @(negedge clk); guard++; end
      @(negedge clk);
      chk(remain == 0 && exp_rem == 0, "R11", "command drained", remain, 0);
   endtask

   task automatic run_cmd(input int total, input int pkl, input bit wr_tot);
      if (pkl != 0) begin write_pay(pkl); exp_pkl = pkl; end
      if (wr_tot) write_tot(total);
      push_bytes(total);
      do_start(total);
      wait_idle();
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      chk(0, "R11", "watchdog expired", 0, 1);
      finish_up();
   end

   initial begin : main
      int sweep [4];
      sweep = '{1, 3, 40, 7};
      repeat (4) @(negedge clk);
      chk(!busy && !tx_valid && !fifo_rd_en && remain == 0, "R1", "reset state",
          {busy, tx_valid, fifo_rd_en}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R3 default payload length: 15 -> 7,7,1
      run_cmd(15, 0, 1);
      // R3 invalid writes ignored: 9 -> 7,2
      write_pay(0);
      write_pay(PAY_MAX + 1);
      run_cmd(9, 0, 1);
      // R3 persistence of total: no rewrite
      run_cmd(9, 0, 0);

      // R2 zero total ignored
      write_tot(0);
      @(negedge clk); start = 1;
      @(negedge clk); start = 0;
      chk(!busy && !tx_valid, "R2", "zero total start ignored", busy, 0);

      // R2/R3 start and payload write while busy are ignored
      write_tot(20);
      push_bytes(20);
      do_start(20);
      repeat (15) @(negedge clk);
      tot_wr = 1; tot_wdata = 5; pay_wr = 1; pay_wdata = 2; start = 1;
      @(negedge clk);
      tot_wr = 0; pay_wr = 0; start = 0;
      wait_idle();
      run_cmd(5, 0, 0);

      // R10 no frame before full payload present
      write_tot(7);
      push_bytes(3);
      saw_valid = 0;
      @(negedge clk); start = 1; exp_rem = 7;
      @(negedge clk); start = 0;
      repeat (60) @(negedge clk);
      chk(!saw_valid, "R10", "frame held for full payload", saw_valid, 0);
      chk(wp - rp == 3, "R10", "fifo untouched", wp - rp, 3);
      push_bytes(4);
      wait_idle();

      // sweep of payload length against totals
      foreach (sweep[s]) begin
         all_rdy = s[0];
         for (int t = 1; t <= 12; t++) run_cmd(t, (t == 1) ? sweep[s] : 0, 1);
         if (sweep[s] >= 7) begin
            run_cmd(40, 0, 1);
            run_cmd(41, 0, 1);
            run_cmd(81, 0, 1);
         end
      end
      all_rdy = 0;
      repeat (5) @(negedge clk);
      finish_up();
   end
endmodule